// File: doc/BRIEF.md
# Packed Pixel Shading and Depth-Test Unit

This block is one step of a span walker for drawing shaded polygons with hidden-surface removal. It takes a 64-bit word that holds several packed pixels. In one cycle it advances the colour intensities of every pixel by a per-step increment, and it advances a packed word of depth values by its own per-step increment. The upstream walker supplies the current colours and depths, which start at the vertex values, together with the constant deltas. It feeds each result back as the next operand.

Each new depth is compared with the value read from the depth buffer. A lane whose new depth is strictly smaller (nearer to the viewer) is visible. The block returns three things. The first is a merged depth word that holds the new depth in visible lanes and the old depth elsewhere. The second is the plain interpolated depth word, for the next step. The third is a byte mask with one bit per byte of the depth word, which can drive the byte enables of a depth-buffer write. The pixel layout is chosen per operation: eight 8-bit intensities, four 16-bit pixels split into 6/5/5 colour fields, or two 32-bit pixels made of three 8-bit colour fields. Depth lanes are 16 or 32 bits wide, chosen by a separate input. Results appear one cycle after the valid strobe, and a new operation can start every cycle.

Top module: `pzs_shade_z`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, so back-to-back operations give back-to-back results.
- R2: With `pix_mode`=00, each of the eight bytes of `color_next` is the sum of the matching bytes of `color_cur` and `color_step`, modulo 256, with no carry into the next byte.
- R3: With `pix_mode`=01, each 16-bit pixel holds red in bits 15:10, green in bits 9:5 and blue in bits 4:0. Each field is summed modulo its own width, with no carry between fields or pixels.
- R4: With `pix_mode`=10 or 11, each 32-bit pixel has colour bytes at bits 7:0, 15:8 and 23:16, each summed modulo 256 with no carry between bytes. Bits 31:24 of each pixel are output as zero.
- R5: `z_next` is `z_cur + z_step` per depth lane, modulo the lane width. The lanes are 16 bits wide when `depth32`=0 and 32 bits wide when `depth32`=1.
- R6: A depth lane is visible only when its `z_next` value is strictly less (unsigned) than the matching `z_stored` lane. Equal depths are hidden.
- R7: `z_write` holds `z_next` in visible lanes and `z_stored` in hidden lanes.
- R8: Bit i of `byte_mask` covers bits 8i+7:8i of the depth word. Every byte of a lane carries that lane's visibility.
- R9: During and right after reset, `out_valid`, `byte_mask` and all data outputs are zero.
- R10: In a cycle after `in_valid` low, all data outputs and `byte_mask` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| pix_mode | input | 2 | Pixel layout: 00 8-bit, 01 16-bit 6/5/5, 1x 32-bit |
| depth32 | input | 1 | Depth lane width: 0 for 16 bits, 1 for 32 bits |
| color_cur | input | 64 | Current packed colour intensities |
| color_step | input | 64 | Packed colour increments |
| z_cur | input | 64 | Current packed depths |
| z_step | input | 64 | Packed depth increments |
| z_stored | input | 64 | Packed depths read from the depth buffer |
| out_valid | output | 1 | Result valid |
| color_next | output | 64 | Interpolated packed colours |
| z_next | output | 64 | Interpolated packed depths |
| z_write | output | 64 | Merged depth word for the buffer write |
| byte_mask | output | 8 | Per-byte write enables from the depth test |

## Verification
The hardest situations to reach from the ports are lane-local boundaries. One is a depth sum that wraps past the top of its lane and so turns into a small, "near" value. Another is a new depth exactly equal to the stored one. A third is a colour field at its maximum that must wrap without disturbing its neighbour. Random operands almost never hit these. The stimulus therefore starts with directed words whose lanes sit at all-ones, at equal depth and at one below or above the stored value, in both depth widths and all pixel layouts. Random traffic with idle gaps follows.

// File: rtl/pzs_pkg.sv
package pzs_pkg;

  typedef enum logic [1:0] {
    PIX_8   = 2'b00,
    PIX_16  = 2'b01,
    PIX_32  = 2'b10,
    PIX_32R = 2'b11
  } pix_mode_e;

  // 8-bit intensity step, wraps
  function automatic logic [7:0] step_i8(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] s;
    s = a + b;
    return s;
  endfunction

  // 16-bit pixel: red[15:10], green[9:5], blue[4:0], fields wrap separately
  function automatic logic [15:0] step_rgb16(input logic [15:0] a, input logic [15:0] b);
    logic [5:0] r;
    logic [4:0] g;
    logic [4:0] bl;
    r  = a[15:10] + b[15:10];
    g  = a[9:5]   + b[9:5];
    bl = a[4:0]   + b[4:0];
    return {r, g, bl};
  endfunction

  // 32-bit pixel: three colour bytes, top byte cleared
  function automatic logic [31:0] step_rgb32(input logic [31:0] a, input logic [31:0] b);
    logic [7:0] c2;
    logic [7:0] c1;
    logic [7:0] c0;
    c2 = a[23:16] + b[23:16];
    c1 = a[15:8]  + b[15:8];
    c0 = a[7:0]   + b[7:0];
    return {8'h00, c2, c1, c0};
  endfunction

endpackage

// File: rtl/pzs_color.sv
module pzs_color
  import pzs_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic [1:0]        pix_mode,
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] step,
  output logic [WORD_W-1:0] next
);
  localparam int N8  = WORD_W / 8;
  localparam int N16 = WORD_W / 16;
  localparam int N32 = WORD_W / 32;

  logic [WORD_W-1:0] res8;
  logic [WORD_W-1:0] res16;
  logic [WORD_W-1:0] res32;

  for (genvar g = 0; g < N8; g++) begin : g_l8
    assign res8[g*8 +: 8] = step_i8(cur[g*8 +: 8], step[g*8 +: 8]);
  end

  for (genvar g = 0; g < N16; g++) begin : g_l16
    assign res16[g*16 +: 16] = step_rgb16(cur[g*16 +: 16], step[g*16 +: 16]);
  end

  for (genvar g = 0; g < N32; g++) begin : g_l32
    assign res32[g*32 +: 32] = step_rgb32(cur[g*32 +: 32], step[g*32 +: 32]);
  end

  always_comb begin
    unique case (pix_mode_e'(pix_mode))
      PIX_8:   next = res8;
      PIX_16:  next = res16;
      default: next = res32;
    endcase
  end
endmodule

// File: rtl/pzs_depth.sv
module pzs_depth #(
  parameter int WORD_W = 64
) (
  input  logic                  depth32,
  input  logic [WORD_W-1:0]     cur,
  input  logic [WORD_W-1:0]     step,
  input  logic [WORD_W-1:0]     stored,
  output logic [WORD_W-1:0]     next,
  output logic [WORD_W-1:0]     merged,
  output logic [WORD_W/8-1:0]   byte_vis
);
  localparam int N16 = WORD_W / 16;
  localparam int N32 = WORD_W / 32;
  localparam int NB  = WORD_W / 8;

  logic [WORD_W-1:0] next16, merge16, next32, merge32;
  logic [NB-1:0]     bytes16, bytes32;
  logic [N16-1:0]    lane_vis16;
  logic [N32-1:0]    lane_vis32;

  for (genvar g = 0; g < N16; g++) begin : g_z16
    logic [15:0] s;
    assign s             = cur[g*16 +: 16] + step[g*16 +: 16];
    assign lane_vis16[g] = s < stored[g*16 +: 16];
    assign next16[g*16 +: 16]  = s;
    assign merge16[g*16 +: 16] = lane_vis16[g] ? s : stored[g*16 +: 16];
    assign bytes16[g*2 +: 2]   = {2{lane_vis16[g]}};
  end

  for (genvar g = 0; g < N32; g++) begin : g_z32
    logic [31:0] s;
    assign s             = cur[g*32 +: 32] + step[g*32 +: 32];
    assign lane_vis32[g] = s < stored[g*32 +: 32];
    assign next32[g*32 +: 32]  = s;
    assign merge32[g*32 +: 32] = lane_vis32[g] ? s : stored[g*32 +: 32];
    assign bytes32[g*4 +: 4]   = {4{lane_vis32[g]}};
  end

  assign next     = depth32 ? next32  : next16;
  assign merged   = depth32 ? merge32 : merge16;
  assign byte_vis = depth32 ? bytes32 : bytes16;
endmodule

// File: rtl/pzs_shade_z.sv
module pzs_shade_z #(
  parameter int WORD_W = 64,
  localparam int NB    = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        pix_mode,
  input  logic              depth32,
  input  logic [WORD_W-1:0] color_cur,
  input  logic [WORD_W-1:0] color_step,
  input  logic [WORD_W-1:0] z_cur,
  input  logic [WORD_W-1:0] z_step,
  input  logic [WORD_W-1:0] z_stored,
  output logic              out_valid,
  output logic [WORD_W-1:0] color_next,
  output logic [WORD_W-1:0] z_next,
  output logic [WORD_W-1:0] z_write,
  output logic [NB-1:0]     byte_mask
);
  logic [WORD_W-1:0] col_d;
  logic [WORD_W-1:0] zn_d;
  logic [WORD_W-1:0] zw_d;
  logic [NB-1:0]     vis_d;

  pzs_color #(.WORD_W(WORD_W)) u_color (
    .pix_mode (pix_mode),
    .cur      (color_cur),
    .step     (color_step),
    .next     (col_d)
  );

  pzs_depth #(.WORD_W(WORD_W)) u_depth (
    .depth32  (depth32),
    .cur      (z_cur),
    .step     (z_step),
    .stored   (z_stored),
    .next     (zn_d),
    .merged   (zw_d),
    .byte_vis (vis_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      color_next <= '0;
      z_next     <= '0;
      z_write    <= '0;
      byte_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        color_next <= col_d;
        z_next     <= zn_d;
        z_write    <= zw_d;
        byte_mask  <= vis_d;
      end
    end
  end
endmodule

// File: rtl/pzs_shade_z_chk.sv
module pzs_shade_z_chk #(
  parameter int WORD_W = 64,
  localparam int NB    = WORD_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        pix_mode,
  input logic              depth32,
  input logic [WORD_W-1:0] z_stored,
  input logic              out_valid,
  input logic [WORD_W-1:0] color_next,
  input logic [WORD_W-1:0] z_next,
  input logic [WORD_W-1:0] z_write,
  input logic [NB-1:0]     byte_mask
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(color_next) && $stable(z_next) && $stable(z_write) && $stable(byte_mask)));
  // R4
  top_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(pix_mode[1])) |-> (color_next[31:24] == 8'h00 && color_next[WORD_W-1 -: 8] == 8'h00));

  for (genvar b = 0; b < NB; b++) begin : g_byte
    // R7
    merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (z_write[b*8 +: 8] == (byte_mask[b] ? z_next[b*8 +: 8] : $past(z_stored[b*8 +: 8]))));
  end

  for (genvar g = 0; g < WORD_W/16; g++) begin : g_l16
    // R8
    pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(depth32)) |-> (byte_mask[2*g] == byte_mask[2*g+1]));
    // R6
    near16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(depth32)) |->
        (byte_mask[2*g] == (z_next[g*16 +: 16] < $past(z_stored[g*16 +: 16]))));
  end

  for (genvar g = 0; g < WORD_W/32; g++) begin : g_l32
    // R8
    quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(depth32)) |-> ($countones(byte_mask[4*g +: 4]) == 0 || byte_mask[4*g +: 4] == 4'hF));
    // R6
    near32_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(depth32)) |->
        (byte_mask[4*g] == (z_next[g*32 +: 32] < $past(z_stored[g*32 +: 32]))));
  end
endmodule

bind pzs_shade_z pzs_shade_z_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .pix_mode   (pix_mode),
  .depth32    (depth32),
  .z_stored   (z_stored),
  .out_valid  (out_valid),
  .color_next (color_next),
  .z_next     (z_next),
  .z_write    (z_write),
  .byte_mask  (byte_mask)
);

// File: tb/pzs_shade_z_test.sv
`timescale 1ns/1ps
module pzs_shade_z_test;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  pix_mode = 2'b00;
  logic        depth32 = 1'b0;
  logic [63:0] color_cur = '0, color_step = '0, z_cur = '0, z_step = '0, z_stored = '0;
  logic        out_valid;
  logic [63:0] color_next, z_next, z_write;
  logic [7:0]  byte_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] col;
    logic [63:0] zn;
    logic [63:0] zw;
    logic [7:0]  mask;
    logic [1:0]  mode;
  } exp_t;

  exp_t sb[$];
  logic [63:0] last_col = '0, last_zn = '0, last_zw = '0;
  logic [7:0]  last_mask = '0;

  always #(HALF) clk = ~clk;

  pzs_shade_z uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_mode(pix_mode), .depth32(depth32),
    .color_cur(color_cur), .color_step(color_step), .z_cur(z_cur), .z_step(z_step),
    .z_stored(z_stored), .out_valid(out_valid), .color_next(color_next), .z_next(z_next),
    .z_write(z_write), .byte_mask(byte_mask)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected colour, masked-field formulation (R2, R3, R4)
  function automatic logic [63:0] ref_color(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    if (m == 2'b00) begin
      for (int i = 0; i < 8; i++) r[i*8 +: 8] = a[i*8 +: 8] + b[i*8 +: 8];
    end else if (m == 2'b01) begin
      for (int i = 0; i < 4; i++) begin
        logic [15:0] x, y, f;
        x = a[i*16 +: 16]; y = b[i*16 +: 16];
        f = (((x & 16'hFC00) + (y & 16'hFC00)) & 16'hFC00)
          | (((x & 16'h03E0) + (y & 16'h03E0)) & 16'h03E0)
          | (((x & 16'h001F) + (y & 16'h001F)) & 16'h001F);
        r[i*16 +: 16] = f;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic [31:0] x, y, f;
        x = a[i*32 +: 32]; y = b[i*32 +: 32];
        f = (((x & 32'h00FF0000) + (y & 32'h00FF0000)) & 32'h00FF0000)
          | (((x & 32'h0000FF00) + (y & 32'h0000FF00)) & 32'h0000FF00)
          | (((x & 32'h000000FF) + (y & 32'h000000FF)) & 32'h000000FF);
        r[i*32 +: 32] = f;
      end
    end
    return r;
  endfunction

  task automatic send(input logic [1:0] m, input logic d32, input logic [63:0] cc, input logic [63:0] cs,
                      input logic [63:0] zc, input logic [63:0] zs, input logic [63:0] zo);
    exp_t e;
    int w, n;
    @(negedge clk);
    in_valid = 1'b1; pix_mode = m; depth32 = d32;
    color_cur = cc; color_step = cs; z_cur = zc; z_step = zs; z_stored = zo;
    e.col = ref_color(m, cc, cs); e.mode = m;
    w = d32 ? 32 : 16; n = 64 / w;
    e.zn = '0; e.zw = '0; e.mask = '0;
    for (int i = 0; i < n; i++) begin
      longint unsigned lm, s, o;
      lm = (64'd1 << w) - 1;
      s = ((zc >> (i*w)) + (zs >> (i*w))) & lm;
      o = (zo >> (i*w)) & lm;
      e.zn = e.zn | (64'(s) << (i*w));
      if (s < o) begin
        e.zw = e.zw | (64'(s) << (i*w));
        e.mask = e.mask | 8'(((1 << (w/8)) - 1) << (i*w/8));
      end else begin
        e.zw = e.zw | (64'(o) << (i*w));
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 actual=out_valid expected=no result");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check64(e.mode == 2'b00 ? "R2" : (e.mode == 2'b01 ? "R3" : "R4"), color_next, e.col);
          check64("R5", z_next, e.zn);
          check64("R7", z_write, e.zw);
          check64("R6 R8", {56'd0, byte_mask}, {56'd0, e.mask});
          last_col = color_next; last_zn = z_next; last_zw = z_write; last_mask = byte_mask;
        end
      end
    end
  end

  initial begin
    #(HALF * 2 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check64("R9", {out_valid, byte_mask, color_next[54:0]}, 64'd0);
    check64("R9", z_next | z_write, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R9 R1", {63'd0, out_valid}, 64'd0);

    // R2: byte wrap without carry into neighbour
    send(2'b00, 1'b0, 64'hFF01_7F80_00FF_1234, 64'h0101_8180_0101_0101,
         64'h0000_FFFF_1000_0005, 64'h0001_0001_0000_0001, 64'h0002_0005_1000_0005);
    // R3: 6/5/5 field wrap; R6 equal and wrapped depth (16-bit lanes)
    send(2'b01, 1'b0, 64'hFFFF_FC00_03E0_001F, 64'h0421_0400_0020_0001,
         64'hFFFE_0010_7FFF_0000, 64'h0002_0000_0001_0000, 64'h0001_0010_8001_0000);
    // R4: 32-bit pixels, top byte cleared; mode 11 reserved path
    send(2'b10, 1'b1, 64'hAAFF_FFFF_5501_0203, 64'hFF01_0101_FFFF_FFFF,
         64'hFFFF_FFFF_0000_0010, 64'h0000_0002_0000_0000, 64'h0000_0005_0000_0010);
    send(2'b11, 1'b1, 64'h1122_3344_5566_7788, 64'h0101_01FF_FFFF_FF01,
         64'h0000_0001_8000_0000, 64'h0000_0000_0000_0001, 64'h0000_0002_8000_0000);
    idle(2);
    // R10 hold after idle
    idle(3);
    check64("R10", color_next, last_col);
    check64("R10", z_next, last_zn);
    check64("R10", z_write, last_zw);
    check64("R10", {56'd0, byte_mask}, {56'd0, last_mask});
    check64("R1", {63'd0, out_valid}, 64'd0);

    // Random traffic with gaps, back to back bursts (R1)
    for (int k = 0; k < 400; k++) begin
      logic [63:0] zc, zo;
      zc = {$urandom, $urandom};
      zo = ($urandom % 4 == 0) ? zc : {$urandom, $urandom};
      send(2'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
           zc, ($urandom % 3 == 0) ? 64'd0 : {$urandom, $urandom}, zo);
      if ($urandom % 5 == 0) idle(1 + ($urandom % 3));
    end
    idle(4);
    check64("R1", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule